// File: doc/BRIEF.md
# Sound Processor Command Mailbox

This block links a main processor and a sound processor through two 16-bit mailboxes running in each direction. The sound processor sees the block as a 16-byte window in its I/O space, at base 0x100 by default. In that window it writes two outgoing latches, reads two incoming latches, and writes an acknowledge location. The main processor writes the incoming latches through a simple strobed write port. It can observe both outgoing latches directly at any time.

A main-side write to incoming latch 1 is treated as a command. It raises a level-5 interrupt request toward the sound processor. The request stays raised until the sound side writes the acknowledge location. Reading a mailbox never clears the request. When a command and an acknowledge arrive in the same cycle, the command wins, so the sound processor cannot miss a command.

Top module: `snd_mailbox`

## Requirements
- R1: A sound-side access takes effect only when snd_addr[15:4] equals 0x010, which is the window 0x100 to 0x10F. Address bit 0 is ignored, so offsets select 16-bit words. An access outside the window changes no latch and no interrupt state, and a read outside the window returns zero.
- R2: A sound-side write at offset 0x0 updates outgoing latch 0 per byte lane. snd_be[0] enables bits 7:0 and snd_be[1] enables bits 15:8. A lane whose enable is clear keeps its old value.
- R3: A sound-side write at offset 0x2 updates outgoing latch 1 with the same per-lane rule as R2.
- R4: A sound-side read at offset 0x4 returns incoming latch 0, and a read at offset 0x6 returns incoming latch 1. The data appears on snd_rdata in the clock cycle after snd_rd is sampled high. In every cycle that follows a cycle without snd_rd, snd_rdata is zero.
- R5: Inside the window, reads at offsets 0x0, 0x2, 0x8, 0xA, 0xC and 0xE return zero. Writes at offsets 0x4, 0x6, 0x8, 0xC and 0xE change nothing.
- R6: A main-side write updates incoming latch main_sel (0 or 1) per byte lane. main_be[0] enables bits 7:0 and main_be[1] enables bits 15:8.
- R7: A main-side write with main_sel = 1 and at least one main_be bit set drives irq_lvl5 high from the next cycle. irq_lvl5 then stays high until it is acknowledged. A write with both main_be bits clear does not raise it.
- R8: A sound-side write at offset 0xA, with any data and any byte enables, drives irq_lvl5 low from the next cycle.
- R9: When a main-side command (R7) and a sound-side acknowledge (R8) occur in the same cycle, irq_lvl5 is high in the next cycle.
- R10: During and after reset, all four latches are zero, irq_lvl5 is low and snd_rdata is zero.
- R11: main_out0 and main_out1 always show outgoing latches 0 and 1. Each one changes in the cycle after the sound-side write that updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_addr | input | 16 | Sound-side I/O byte address |
| snd_wr | input | 1 | Sound-side write strobe |
| snd_rd | input | 1 | Sound-side read strobe |
| snd_be | input | 2 | Sound-side byte-lane enables |
| snd_wdata | input | 16 | Sound-side write data |
| snd_rdata | output | 16 | Sound-side read data, one cycle after the read |
| main_wr | input | 1 | Main-side write strobe |
| main_sel | input | 1 | Main-side incoming latch select |
| main_be | input | 2 | Main-side byte-lane enables |
| main_wdata | input | 16 | Main-side write data |
| main_out0 | output | 16 | Outgoing latch 0 |
| main_out1 | output | 16 | Outgoing latch 1 |
| irq_lvl5 | output | 1 | Level-5 interrupt request to the sound processor |

## Verification
A decode fault, such as a slot matched at the wrong offset, a missed window check or a lost byte lane, corrupts a latch. An outgoing latch shows the error on main_out0 or main_out1 one cycle after the write. An incoming latch shows it on snd_rdata one cycle after the next read. A wrong interrupt state appears on irq_lvl5 in the cycle after the command or acknowledge that exposes it, and the same-cycle collision is the case that separates the two priority orders. The bench compares every output against a behavioural model on every cycle, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

   // Per-cycle decoded sound-side access, one strobe per action
   typedef struct packed {
      logic wr_out0;
      logic wr_out1;
      logic ack;
      logic rd_in0;
      logic rd_in1;
   } mbx_dec_t;

   localparam int unsigned MBX_NBOX = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mbx_addr_dec.sv
`timescale 1ns/1ps
module mbx_addr_dec
   import mbx_pkg::*;
#(
   parameter int unsigned IO_AW     = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BASE      = 'h100,
   parameter int unsigned WIN_BYTES = 16,
   parameter int unsigned OUT0_OFS  = 'h0,
   parameter int unsigned OUT1_OFS  = 'h2,
   parameter int unsigned IN0_OFS   = 'h4,
   parameter int unsigned IN1_OFS   = 'h6,
   parameter int unsigned ACK_OFS   = 'hA
) (
   input  logic [IO_AW-1:0] addr,
   input  logic             wr,
   input  logic             rd,
   output mbx_dec_t         dec
);
   localparam int unsigned BYTES_W  = DATA_W / 8;
   localparam int unsigned LANE_LOG = (BYTES_W > 1) ? $clog2(BYTES_W) : 0;
   localparam int unsigned WIN_LOG  = $clog2(WIN_BYTES);
   localparam int unsigned NSLOT    = WIN_BYTES / BYTES_W;
   localparam int unsigned IDX_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam logic [IO_AW-1:0] BASE_V = IO_AW'(BASE);

   // Elaboration-time parameter checks
   if ((DATA_W % 8) != 0 || !is_pow2(BYTES_W)) begin : g_bad_width
      $error("mbx_addr_dec: DATA_W must be a power-of-two count of bytes");
   end
   if (!is_pow2(WIN_BYTES) || WIN_BYTES < 4 * BYTES_W || WIN_LOG >= IO_AW) begin : g_bad_win
      $error("mbx_addr_dec: WIN_BYTES must be a power of two fitting the address");
   end
   if ((BASE % WIN_BYTES) != 0) begin : g_bad_base
      $error("mbx_addr_dec: BASE must be aligned to the window size");
   end
   if (OUT0_OFS >= WIN_BYTES || OUT1_OFS >= WIN_BYTES || IN0_OFS >= WIN_BYTES ||
       IN1_OFS >= WIN_BYTES || ACK_OFS >= WIN_BYTES) begin : g_bad_ofs
      $error("mbx_addr_dec: every offset must lie inside the window");
   end
   if ((OUT0_OFS % BYTES_W) != 0 || (OUT1_OFS % BYTES_W) != 0 || (IN0_OFS % BYTES_W) != 0 ||
       (IN1_OFS % BYTES_W) != 0 || (ACK_OFS % BYTES_W) != 0) begin : g_bad_align
      $error("mbx_addr_dec: every offset must be word aligned");
   end
   if (OUT0_OFS == OUT1_OFS || OUT0_OFS == ACK_OFS || OUT1_OFS == ACK_OFS ||
       IN0_OFS == IN1_OFS) begin : g_bad_overlap
      $error("mbx_addr_dec: write targets and read targets must be distinct");
   end

   logic             win_hit;
   logic [IDX_W-1:0] slot_idx;
   logic [NSLOT-1:0] slot_hit;

   assign win_hit = (addr[IO_AW-1:WIN_LOG] == BASE_V[IO_AW-1:WIN_LOG]);

   if (LANE_LOG > 0) begin : g_lane_bits
      logic lane_bits_unused;
      assign lane_bits_unused = ^addr[LANE_LOG-1:0];
   end

   if (WIN_LOG > LANE_LOG) begin : g_idx
      assign slot_idx = IDX_W'(addr[WIN_LOG-1:LANE_LOG]);
   end else begin : g_idx_zero
      assign slot_idx = '0;
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_hit[s] = win_hit && (slot_idx == IDX_W'(s));
   end

   assign dec.wr_out0 = wr && slot_hit[OUT0_OFS / BYTES_W];
   assign dec.wr_out1 = wr && slot_hit[OUT1_OFS / BYTES_W];
   assign dec.ack     = wr && slot_hit[ACK_OFS  / BYTES_W];
   assign dec.rd_in0  = rd && slot_hit[IN0_OFS  / BYTES_W];
   assign dec.rd_in1  = rd && slot_hit[IN1_OFS  / BYTES_W];

endmodule

// File: rtl/mbx_lane_reg.sv
`timescale 1ns/1ps
module mbx_lane_reg #(
   parameter int unsigned DATA_W = 16,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   q
);
   localparam int unsigned NLANE = DATA_W / 8;

   if ((DATA_W % 8) != 0 || DATA_W == 0) begin : g_bad_width
      $error("mbx_lane_reg: DATA_W must be a nonzero multiple of 8");
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[l*8 +: 8] <= RST_VAL[l*8 +: 8];
         end else if (we && be[l]) begin
            q[l*8 +: 8] <= wdata[l*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/mbx_irq_ctl.sv
`timescale 1ns/1ps
module mbx_irq_ctl #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic irq
);
   logic irq_nxt;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (set_req)      irq_nxt = 1'b1;
         else if (clr_req) irq_nxt = 1'b0;
         else              irq_nxt = irq;
      end
   end else begin : g_clr_first
      always_comb begin
         if (clr_req)      irq_nxt = 1'b0;
         else if (set_req) irq_nxt = 1'b1;
         else              irq_nxt = irq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_nxt;
   end

endmodule

// File: rtl/snd_mailbox.sv
`timescale 1ns/1ps
module snd_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned IO_AW     = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BASE      = 'h100,
   parameter int unsigned WIN_BYTES = 16,
   parameter int unsigned OUT0_OFS  = 'h0,
   parameter int unsigned OUT1_OFS  = 'h2,
   parameter int unsigned IN0_OFS   = 'h4,
   parameter int unsigned IN1_OFS   = 'h6,
   parameter int unsigned ACK_OFS   = 'hA,
   parameter int unsigned CMD_BOX   = 1,
   parameter bit          RD_REG    = 1'b1,
   parameter bit          SET_WINS  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IO_AW-1:0]    snd_addr,
   input  logic                snd_wr,
   input  logic                snd_rd,
   input  logic [DATA_W/8-1:0] snd_be,
   input  logic [DATA_W-1:0]   snd_wdata,
   output logic [DATA_W-1:0]   snd_rdata,
   input  logic                main_wr,
   input  logic                main_sel,
   input  logic [DATA_W/8-1:0] main_be,
   input  logic [DATA_W-1:0]   main_wdata,
   output logic [DATA_W-1:0]   main_out0,
   output logic [DATA_W-1:0]   main_out1,
   output logic                irq_lvl5
);
   localparam int unsigned NBOX = MBX_NBOX;

   if (CMD_BOX >= NBOX) begin : g_bad_cmd
      $error("snd_mailbox: CMD_BOX must name an existing incoming latch");
   end

   mbx_dec_t          dec;
   logic [NBOX-1:0]   out_we;
   logic [NBOX-1:0]   in_we;
   logic [DATA_W-1:0] out_q [NBOX];
   logic [DATA_W-1:0] in_q  [NBOX];
   logic [DATA_W-1:0] rd_val;
   logic              cmd_set;

   mbx_addr_dec #(
      .IO_AW(IO_AW), .DATA_W(DATA_W), .BASE(BASE), .WIN_BYTES(WIN_BYTES),
      .OUT0_OFS(OUT0_OFS), .OUT1_OFS(OUT1_OFS), .IN0_OFS(IN0_OFS),
      .IN1_OFS(IN1_OFS), .ACK_OFS(ACK_OFS)
   ) u_dec (
      .addr (snd_addr),
      .wr   (snd_wr),
      .rd   (snd_rd),
      .dec  (dec)
   );

   assign out_we = {dec.wr_out1, dec.wr_out0};

   for (genvar b = 0; b < NBOX; b++) begin : g_box
      assign in_we[b] = main_wr && (main_sel == 1'(b));

      mbx_lane_reg #(.DATA_W(DATA_W)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (out_we[b]),
         .be    (snd_be),
         .wdata (snd_wdata),
         .q     (out_q[b])
      );

      mbx_lane_reg #(.DATA_W(DATA_W)) u_in (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (in_we[b]),
         .be    (main_be),
         .wdata (main_wdata),
         .q     (in_q[b])
      );
   end

   assign main_out0 = out_q[0];
   assign main_out1 = out_q[1];

   // Read selection: at most one strobe is active, anything else reads zero
   always_comb begin
      if (dec.rd_in0)      rd_val = in_q[0];
      else if (dec.rd_in1) rd_val = in_q[1];
      else                 rd_val = '0;
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_val;
      end
      assign snd_rdata = rdata_q;
   end else begin : g_rd_comb
      assign snd_rdata = rd_val;
   end

   assign cmd_set = in_we[CMD_BOX] && (|main_be);

   mbx_irq_ctl #(.SET_WINS(SET_WINS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (cmd_set),
      .clr_req (dec.ack),
      .irq     (irq_lvl5)
   );

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
   parameter int unsigned IO_AW     = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BASE      = 'h100,
   parameter int unsigned WIN_BYTES = 16,
   parameter int unsigned OUT0_OFS  = 'h0,
   parameter int unsigned OUT1_OFS  = 'h2,
   parameter int unsigned ACK_OFS   = 'hA,
   parameter int unsigned CMD_BOX   = 1,
   parameter bit          RD_REG    = 1'b1,
   parameter bit          SET_WINS  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [IO_AW-1:0]    snd_addr,
   input logic                snd_wr,
   input logic                snd_rd,
   input logic [DATA_W/8-1:0] snd_be,
   input logic [DATA_W-1:0]   snd_wdata,
   input logic [DATA_W-1:0]   snd_rdata,
   input logic                main_wr,
   input logic                main_sel,
   input logic [DATA_W/8-1:0] main_be,
   input logic [DATA_W-1:0]   main_out0,
   input logic [DATA_W-1:0]   main_out1,
   input logic                irq_lvl5
);
   localparam int unsigned WIN_LOG = $clog2(WIN_BYTES);
   localparam logic [IO_AW-1:0] BASE_V = IO_AW'(BASE);

   logic             in_win;
   logic [IO_AW-1:0] ofs;
   logic             w_out0, w_out1, w_ack, c_set;

   assign in_win = (snd_addr[IO_AW-1:WIN_LOG] == BASE_V[IO_AW-1:WIN_LOG]);
   assign ofs    = snd_addr - BASE_V;
   assign w_out0 = snd_wr && in_win && ((ofs >> 1) == IO_AW'(OUT0_OFS / 2));
   assign w_out1 = snd_wr && in_win && ((ofs >> 1) == IO_AW'(OUT1_OFS / 2));
   assign w_ack  = snd_wr && in_win && ((ofs >> 1) == IO_AW'(ACK_OFS / 2));
   assign c_set  = main_wr && (main_sel == 1'(CMD_BOX)) && (main_be != '0);

   p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      c_set |=> irq_lvl5);

   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_set && !w_ack) |=> $stable(irq_lvl5));

   p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ack && !c_set) |=> !irq_lvl5);

   if (SET_WINS) begin : g_prio
      p_irq_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (w_ack && c_set) |=> irq_lvl5);
   end

   p_out0_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (w_out0 && (&snd_be)) |=> (main_out0 == $past(snd_wdata)));

   p_out0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !w_out0 |=> $stable(main_out0));

   p_out1_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !w_out1 |=> $stable(main_out1));

   if (RD_REG) begin : g_rd
      p_rd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !snd_rd |=> (snd_rdata == '0));

      p_rd_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (snd_rd && !in_win) |=> (snd_rdata == '0));
   end

endmodule

bind snd_mailbox mbx_checker #(
   .IO_AW(IO_AW), .DATA_W(DATA_W), .BASE(BASE), .WIN_BYTES(WIN_BYTES),
   .OUT0_OFS(OUT0_OFS), .OUT1_OFS(OUT1_OFS), .ACK_OFS(ACK_OFS),
   .CMD_BOX(CMD_BOX), .RD_REG(RD_REG), .SET_WINS(SET_WINS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .snd_addr  (snd_addr),
   .snd_wr    (snd_wr),
   .snd_rd    (snd_rd),
   .snd_be    (snd_be),
   .snd_wdata (snd_wdata),
   .snd_rdata (snd_rdata),
   .main_wr   (main_wr),
   .main_sel  (main_sel),
   .main_be   (main_be),
   .main_out0 (main_out0),
   .main_out1 (main_out1),
   .irq_lvl5  (irq_lvl5)
);

// File: tb/snd_mailbox_tb.sv
`timescale 1ns/1ps
module snd_mailbox_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] snd_addr = '0;
   logic        snd_wr = 1'b0;
   logic        snd_rd = 1'b0;
   logic [1:0]  snd_be = '0;
   logic [15:0] snd_wdata = '0;
   logic [15:0] snd_rdata;
   logic        main_wr = 1'b0;
   logic        main_sel = 1'b0;
   logic [1:0]  main_be = '0;
   logic [15:0] main_wdata = '0;
   logic [15:0] main_out0;
   logic [15:0] main_out1;
   logic        irq_lvl5;

   always #2.5 clk = ~clk;

   snd_mailbox dut_i (
      .clk(clk), .rst_n(rst_n),
      .snd_addr(snd_addr), .snd_wr(snd_wr), .snd_rd(snd_rd), .snd_be(snd_be),
      .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
      .main_wr(main_wr), .main_sel(main_sel), .main_be(main_be), .main_wdata(main_wdata),
      .main_out0(main_out0), .main_out1(main_out1), .irq_lvl5(irq_lvl5)
   );

   // Behavioural reference model
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   bit          cmp_en = 1'b0;
   string       cur_req = "R10";
   logic [15:0] m_out [2];
   logic [15:0] m_in  [2];
   logic [15:0] m_rd;
   logic        m_irq;

   function automatic logic [15:0] lanes(input logic [15:0] old, input logic [1:0] be,
                                         input logic [15:0] d);
      logic [15:0] r;
      r = old;
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out[0] = '0; m_out[1] = '0; m_in[0] = '0; m_in[1] = '0;
         m_rd = '0; m_irq = 1'b0;
      end else begin
         int  word;
         bit  hit;
         bit  setc;
         bit  ackc;
         hit  = (snd_addr[15:4] == 12'h010);
         word = int'(snd_addr[3:1]);
         m_rd = '0;
         if (snd_rd && hit && word == 2) m_rd = m_in[0];
         if (snd_rd && hit && word == 3) m_rd = m_in[1];
         if (snd_wr && hit && word == 0) m_out[0] = lanes(m_out[0], snd_be, snd_wdata);
         if (snd_wr && hit && word == 1) m_out[1] = lanes(m_out[1], snd_be, snd_wdata);
         ackc = snd_wr && hit && word == 5;
         setc = main_wr && main_sel && (main_be != 2'b00);
         if (main_wr) m_in[main_sel] = lanes(m_in[main_sel], main_be, main_wdata);
         if (setc)      m_irq = 1'b1;
         else if (ackc) m_irq = 1'b0;
      end
   end

   task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // Compare every output on every falling edge
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         check("main_out0", main_out0, m_out[0]);
         check("main_out1", main_out1, m_out[1]);
         check("snd_rdata", snd_rdata, m_rd);
         check("irq_lvl5", {15'd0, irq_lvl5}, {15'd0, m_irq});
      end
   end

   task automatic cyc(input bit swr, input bit srd, input logic [15:0] a, input logic [1:0] sbe,
                      input logic [15:0] sd, input bit mwr, input bit msel,
                      input logic [1:0] mbe, input logic [15:0] md);
      @(posedge clk); #1;
      snd_wr = swr; snd_rd = srd; snd_addr = a; snd_be = sbe; snd_wdata = sd;
      main_wr = mwr; main_sel = msel; main_be = mbe; main_wdata = md;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, '0, 0, 0, '0, '0);
   endtask

   task automatic swrite(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
      cyc(1, 0, a, be, d, 0, 0, '0, '0);
   endtask

   task automatic sread(input logic [15:0] a);
      cyc(0, 1, a, '0, '0, 0, 0, '0, '0);
   endtask

   task automatic mwrite(input bit sel, input logic [1:0] be, input logic [15:0] d);
      cyc(0, 0, '0, '0, '0, 1, sel, be, d);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      #1 cmp_en = 1'b1;
      #20;
      // R10: reset state, observed during and after reset
      @(posedge clk); #1 rst_n = 1'b1;
      idle(3);

      cur_req = "R2 R11";
      swrite(16'h0100, 2'b11, 16'hA1B2);
      swrite(16'h0100, 2'b01, 16'h3344);
      swrite(16'h0100, 2'b10, 16'h5566);
      swrite(16'h0100, 2'b00, 16'hFFFF);
      idle(1);

      cur_req = "R3 R11";
      swrite(16'h0102, 2'b11, 16'h1234);
      swrite(16'h0103, 2'b10, 16'hEE00);
      swrite(16'h0102, 2'b01, 16'h00CD);
      idle(1);

      cur_req = "R6";
      mwrite(0, 2'b11, 16'hBEEF);
      mwrite(0, 2'b01, 16'h0011);
      mwrite(1, 2'b10, 16'h7700);
      cur_req = "R4";
      sread(16'h0104);
      sread(16'h0106);
      idle(1);
      sread(16'h0107);
      sread(16'h0105);
      idle(2);

      cur_req = "R7";
      mwrite(1, 2'b11, 16'h0042);
      idle(4);
      sread(16'h0106);
      idle(2);
      cur_req = "R8";
      swrite(16'h010A, 2'b00, 16'h0000);
      idle(2);
      cur_req = "R7";
      mwrite(1, 2'b00, 16'hFFFF);
      idle(2);
      mwrite(0, 2'b11, 16'h9999);
      idle(2);
      mwrite(1, 2'b01, 16'h0001);
      cur_req = "R8";
      swrite(16'h010B, 2'b11, 16'hFFFF);
      idle(2);

      cur_req = "R9";
      cyc(1, 0, 16'h010A, 2'b11, 16'h0000, 1, 1, 2'b11, 16'hC0DE);
      idle(3);
      cyc(1, 0, 16'h010A, 2'b01, 16'h0000, 1, 1, 2'b10, 16'hD000);
      idle(2);
      swrite(16'h010A, 2'b11, 16'h0001);
      idle(1);

      cur_req = "R5";
      mwrite(0, 2'b11, 16'h5A5A);
      mwrite(1, 2'b11, 16'hA5A5);
      swrite(16'h0104, 2'b11, 16'h1111);
      swrite(16'h0106, 2'b11, 16'h2222);
      swrite(16'h0108, 2'b11, 16'h3333);
      swrite(16'h010C, 2'b11, 16'h4444);
      swrite(16'h010E, 2'b11, 16'h5555);
      sread(16'h0104);
      sread(16'h0106);
      sread(16'h0100);
      sread(16'h0102);
      sread(16'h0108);
      sread(16'h010A);
      sread(16'h010C);
      sread(16'h010E);
      idle(2);

      cur_req = "R1";
      swrite(16'h0000, 2'b11, 16'hDEAD);
      swrite(16'h0200, 2'b11, 16'hDEAD);
      swrite(16'h0110, 2'b11, 16'hDEAD);
      swrite(16'h00F2, 2'b11, 16'hDEAD);
      swrite(16'h020A, 2'b11, 16'h0000);
      swrite(16'h000A, 2'b11, 16'h0000);
      sread(16'h0004);
      sread(16'h0114);
      sread(16'h0206);
      idle(2);
      swrite(16'h010A, 2'b11, 16'h0000);
      idle(2);

      cur_req = "R10";
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1;
      @(posedge clk); #1 rst_n = 1'b1;
      idle(3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule